// File: doc/BRIEF.md
# Idle-Detect Update Enable Controller

This block decides when a group of state-holding logic may stop updating. Each cycle it receives change flags from three sources: datapath registers, controller state registers, and attached peripheral or library blocks. If, in a single cycle, none of the three groups reports a change, later cycles cannot produce anything new. The block then drops its enable output on the following clock edge. That output drives a clock-gate enable or a register update enable.

Once the block is asleep, the change flags are ignored. Only an external wake request, for example a processor write that reaches the gated logic, turns the enable back on. After a wake, the enable stays high for one whole cycle before the quiet test runs again, so the woken logic gets one full evaluate-and-update cycle. A status output shows the current sleep state. A saturating counter records how many times the block has entered sleep.

Top module: `idle_gate_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block awake (`run_en`=1, `asleep`=0) with `sleep_cnt`=0. The first cycle after reset is a guard cycle in which no sleep test is made.
- R2: When the block is awake, outside a guard cycle, with every bit of `dp_chg`, `ctl_chg` and `lib_chg` low and `wake_req` low, `run_en` goes to 0 and `asleep` goes to 1 from the next clock cycle.
- R3: When the block is awake and any bit of `dp_chg` is high, it stays awake in the next cycle.
- R4: When the block is awake and any bit of `ctl_chg` is high, it stays awake in the next cycle.
- R5: When the block is awake and any bit of `lib_chg` is high, it stays awake in the next cycle.
- R6: While the block is asleep with `wake_req` low, the change flags have no effect: `asleep` stays 1 and `sleep_cnt` is unchanged.
- R7: `wake_req` high while the block is asleep makes `run_en`=1 and `asleep`=0 from the next cycle.
- R8: The first awake cycle after a wake is a guard cycle. An all-quiet input in that cycle does not cause sleep, so `run_en` stays high for at least two cycles after a wake.
- R9: `wake_req` high while the block is awake counts as activity and blocks sleep entry in that cycle.
- R10: `run_en` is always the inverse of `asleep`.
- R11: `sleep_cnt` rises by exactly one on each sleep entry and holds at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dp_chg | input | NUM_DP | Per-register change flags from the datapath group |
| ctl_chg | input | NUM_CTL | Change flags from controller state registers |
| lib_chg | input | NUM_LIB | Change-of-state flags from attached blocks |
| wake_req | input | 1 | External wake request |
| run_en | output | 1 | Update / clock-gate enable for the watched logic |
| asleep | output | 1 | High while the watched logic is held |
| sleep_cnt | output | CNT_W | Saturating count of sleep entries |

## Verification
The bench first drives a quiet cycle straight after reset and straight after a wake. A design that skips the guard cycle would go to sleep there at once. Each change group is raised alone, with the other two quiet. A design that ignores one group, or that needs all three groups active at once, would sleep when it should not. The bench raises flags and activity while the block is asleep to catch a design that lets internal activity end sleep. It drives `wake_req` during an otherwise quiet awake cycle to catch a design that enters sleep on that request. It runs more sleep cycles than a narrow counter can hold, which exposes a counter that wraps to zero.

// File: rtl/idle_gate_pkg.sv
package idle_gate_pkg;
   typedef enum logic {
      PH_RUN   = 1'b0,
      PH_SLEEP = 1'b1
   } phase_t;

   localparam int unsigned GROUP_COUNT = 3;
   localparam int unsigned GRP_DP  = 0;
   localparam int unsigned GRP_CTL = 1;
   localparam int unsigned GRP_LIB = 2;
endpackage

// File: rtl/idle_activity_merge.sv
module idle_activity_merge #(
   parameter int unsigned NUM_DP  = 8,
   parameter int unsigned NUM_CTL = 2,
   parameter int unsigned NUM_LIB = 2
) (
   input  logic [NUM_DP-1:0]  dp_chg,
   input  logic [NUM_CTL-1:0] ctl_chg,
   input  logic [NUM_LIB-1:0] lib_chg,
   input  logic               wake_req,
   output logic               all_quiet
);
   import idle_gate_pkg::*;

   logic [GROUP_COUNT-1:0] grp_busy;

   always_comb begin
      grp_busy          = '0;
      grp_busy[GRP_DP]  = |dp_chg;
      grp_busy[GRP_CTL] = |ctl_chg;
      grp_busy[GRP_LIB] = |lib_chg;
   end

   // Quiet only when every group is silent and nobody asks to wake.
   assign all_quiet = (grp_busy == '0) && !wake_req;
endmodule

// File: rtl/idle_sleep_fsm.sv
module idle_sleep_fsm (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  all_quiet,
   input  logic                  wake_req,
   output idle_gate_pkg::phase_t phase,
   output logic                  guard,
   output logic                  enter
);
   import idle_gate_pkg::*;

   assign enter = (phase == PH_RUN) && !guard && all_quiet;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_RUN;
         guard <= 1'b1;
      end else begin
         case (phase)
            PH_RUN: begin
               guard <= 1'b0;
               if (enter) phase <= PH_SLEEP;
            end
            PH_SLEEP: begin
               if (wake_req) begin
                  phase <= PH_RUN;
                  guard <= 1'b1;
               end
            end
            default: phase <= PH_RUN;
         endcase
      end
   end
endmodule

// File: rtl/idle_entry_counter.sv
module idle_entry_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst)                          count <= '0;
      else if (bump && count != CNT_MAX) count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/idle_gate_ctrl.sv
module idle_gate_ctrl #(
   parameter int unsigned NUM_DP  = 8,
   parameter int unsigned NUM_CTL = 2,
   parameter int unsigned NUM_LIB = 2,
   parameter int unsigned CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_DP-1:0]  dp_chg,
   input  logic [NUM_CTL-1:0] ctl_chg,
   input  logic [NUM_LIB-1:0] lib_chg,
   input  logic               wake_req,
   output logic               run_en,
   output logic               asleep,
   output logic [CNT_W-1:0]   sleep_cnt
);
   import idle_gate_pkg::*;

   if (NUM_DP < 1 || NUM_CTL < 1 || NUM_LIB < 1) begin : g_bad_groups
      $error("idle_gate_ctrl: every change group needs at least one flag");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("idle_gate_ctrl: CNT_W must lie in 1..32");
   end

   logic   quiet_w;
   logic   guard_w;
   logic   enter_w;
   phase_t phase_w;

   idle_activity_merge #(
      .NUM_DP (NUM_DP),
      .NUM_CTL(NUM_CTL),
      .NUM_LIB(NUM_LIB)
   ) u_merge (
      .dp_chg   (dp_chg),
      .ctl_chg  (ctl_chg),
      .lib_chg  (lib_chg),
      .wake_req (wake_req),
      .all_quiet(quiet_w)
   );

   idle_sleep_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .all_quiet(quiet_w),
      .wake_req (wake_req),
      .phase    (phase_w),
      .guard    (guard_w),
      .enter    (enter_w)
   );

   idle_entry_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .bump (enter_w),
      .count(sleep_cnt)
   );

   assign asleep = (phase_w == PH_SLEEP);
   assign run_en = (phase_w == PH_RUN);
endmodule

// File: rtl/idle_gate_ctrl_chk.sv
module idle_gate_ctrl_chk #(
   parameter int unsigned NUM_DP  = 8,
   parameter int unsigned NUM_CTL = 2,
   parameter int unsigned NUM_LIB = 2,
   parameter int unsigned CNT_W   = 16
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_DP-1:0]  dp_chg,
   input logic [NUM_CTL-1:0] ctl_chg,
   input logic [NUM_LIB-1:0] lib_chg,
   input logic               wake_req,
   input logic               run_en,
   input logic               asleep,
   input logic [CNT_W-1:0]   sleep_cnt,
   input logic               guard_w
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   p_quiet_sleeps_r2: assert property (@(posedge clk) disable iff (rst)
      (!asleep && !guard_w && !(|dp_chg) && !(|ctl_chg) && !(|lib_chg) && !wake_req) |=> asleep);

   p_dp_keeps_r3: assert property (@(posedge clk) disable iff (rst)
      (!asleep && (|dp_chg)) |=> !asleep);

   p_ctl_keeps_r4: assert property (@(posedge clk) disable iff (rst)
      (!asleep && (|ctl_chg)) |=> !asleep);

   p_lib_keeps_r5: assert property (@(posedge clk) disable iff (rst)
      (!asleep && (|lib_chg)) |=> !asleep);

   p_sleep_holds_r6: assert property (@(posedge clk) disable iff (rst)
      (asleep && !wake_req) |=> (asleep && $stable(sleep_cnt)));

   p_wake_r7: assert property (@(posedge clk) disable iff (rst)
      (asleep && wake_req) |=> !asleep);

   p_guard_r8: assert property (@(posedge clk) disable iff (rst)
      (asleep && wake_req) |=> ##1 !asleep);

   p_wake_awake_r9: assert property (@(posedge clk) disable iff (rst)
      (!asleep && wake_req) |=> !asleep);

   p_enable_inverse_r10: assert property (@(posedge clk) disable iff (rst)
      run_en != asleep);

   p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
      $rose(asleep) |-> ((sleep_cnt == $past(sleep_cnt) + CNT_W'(1)) ||
                         ($past(sleep_cnt) == CNT_TOP && sleep_cnt == CNT_TOP)));
endmodule

bind idle_gate_ctrl idle_gate_ctrl_chk #(
   .NUM_DP (NUM_DP),
   .NUM_CTL(NUM_CTL),
   .NUM_LIB(NUM_LIB),
   .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/idle_gate_ctrl_test.sv
module idle_gate_ctrl_test;
   localparam int NDP = 3;
   localparam int NCT = 2;
   localparam int NLB = 2;
   localparam int CW  = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NDP-1:0] dp_chg = '0;
   logic [NCT-1:0] ctl_chg = '0;
   logic [NLB-1:0] lib_chg = '0;
   logic           wake_req = 1'b0;
   logic           run_en;
   logic           asleep;
   logic [CW-1:0]  sleep_cnt;

   int total = 0;
   int bad = 0;
   int m_sleep = 0;
   int m_guard = 1;
   int m_cnt = 0;

   always #5 clk = ~clk;

   idle_gate_ctrl #(.NUM_DP(NDP), .NUM_CTL(NCT), .NUM_LIB(NLB), .CNT_W(CW)) uut (
      .clk(clk), .rst(rst), .dp_chg(dp_chg), .ctl_chg(ctl_chg), .lib_chg(lib_chg),
      .wake_req(wake_req), .run_en(run_en), .asleep(asleep), .sleep_cnt(sleep_cnt)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one cycle of stimulus, advance the model at the edge, compare after it.
   task automatic step(input string tag, input logic r, input int dp, input int ct,
                       input int lb, input logic wk);
      rst = r; dp_chg = NDP'(dp); ctl_chg = NCT'(ct); lib_chg = NLB'(lb); wake_req = wk;
      @(posedge clk);
      if (r) begin
         m_sleep = 0; m_guard = 1; m_cnt = 0;
      end else if (m_sleep == 1) begin
         if (wk) begin m_sleep = 0; m_guard = 1; end
      end else begin
         if (m_guard == 0 && dp == 0 && ct == 0 && lb == 0 && !wk) begin
            m_sleep = 1;
            if (m_cnt < CMAX) m_cnt++;
         end
         m_guard = 0;
      end
      @(negedge clk);
      check({tag, " asleep"}, int'(asleep), m_sleep);
      check("R10 run_en", int'(run_en), 1 - m_sleep);
      check("R11 sleep_cnt", int'(sleep_cnt), m_cnt);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      step("R1", 1, 0, 0, 0, 0);
      step("R1", 1, 1, 1, 1, 1);
      check("R1 reset cnt", int'(sleep_cnt), 0);
      step("R8", 0, 0, 0, 0, 0);       // guard after reset
      step("R3", 0, 3'b100, 0, 0, 0);
      step("R3", 0, 3'b001, 0, 0, 0);
      step("R2", 0, 0, 0, 0, 0);       // enter sleep
      step("R6", 0, 3'b111, 0, 0, 0);
      step("R6", 0, 0, 2'b11, 2'b01, 0);
      step("R6", 0, 0, 0, 2'b10, 0);
      step("R7", 0, 0, 0, 0, 1);       // wake
      step("R8", 0, 0, 0, 0, 0);       // guard, quiet
      step("R4", 0, 0, 2'b10, 0, 0);
      step("R5", 0, 0, 0, 2'b01, 0);
      step("R9", 0, 0, 0, 0, 1);
      step("R2", 0, 0, 0, 0, 0);
      step("R7", 0, 1, 0, 0, 1);
      step("R4", 0, 0, 2'b01, 0, 0);
      step("R2", 0, 0, 0, 0, 0);
      for (int i = 0; i < 18; i++) begin
         step("R7", 0, 0, 0, 0, 1);
         step("R8", 0, 0, 0, 0, 0);
         step("R11", 0, 0, 0, 0, 0);
      end
      check("R11 saturated", int'(sleep_cnt), CMAX);
      step("R1", 1, 0, 0, 0, 0);       // reset while asleep
      step("R8", 0, 0, 0, 0, 0);
      step("R2", 0, 0, 0, 0, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule